// File: doc/BRIEF.md
# Reset Line Controller with Pushbutton Debounce and Power-Fail Hold

This block owns a single active-low, open-drain reset line that two sources share. A supply monitor elsewhere on the chip reports loss of main power as a flag. While that flag is set, the controller pulls the line low. When the flag clears, it keeps the line low for a recovery interval. The recovery interval is skipped when the oscillator reports that it is not running.

The same line also senses a pushbutton wired to ground. The pin level passes through a synchroniser. A high-to-low transition seen while the controller is idle starts a button sequence:
1. The controller pulls the line low itself for a debounce interval.
2. It lets go and waits until the line reads high, which means the button has been released.
3. It then pulls the line low for a fixed reset pulse.

All intervals are parameters counted in clock ticks.

Only the reset line is affected. Nothing else in the chip is disturbed. A busy flag reports that a sequence of either kind is in progress.

Top module: `pbrst_ctl`

## Requirements
- R1: After reset, `pull_low_o` and `busy_o` are both 0.
- R2: When `pin_i` falls while idle, `pull_low_o` goes to 1 on the third rising clock edge after the change. It stays 1 for exactly `DEBOUNCE_TICKS` cycles.
- R3: After debounce, `pull_low_o` is 0 and `busy_o` stays 1 for as long as `pin_i` stays low.
- R4: Once the synchronised pin reads high after debounce, `pull_low_o` is 1 for exactly `RESET_TICKS` cycles. After that the controller returns to idle and `busy_o` is 0.
- R5: The controller's own low drive never counts as a new press. A button sequence produces exactly two low runs and then stays idle.
- R6: While `pwr_fail_i` is 1, `pull_low_o` is 1 from the next clock edge onward.
- R7: When `pwr_fail_i` clears with `osc_run_i` = 1, `pull_low_o` stays 1 for exactly `RECOVER_TICKS` more cycles.
- R8: When `pwr_fail_i` clears with `osc_run_i` = 0, `pull_low_o` drops on the first clock edge that sees the flag clear.
- R9: `pwr_fail_i` has priority over any button state and aborts a button sequence in progress. Button activity while power has failed, or while the line is held after a failure, starts no sequence.
- R10: `busy_o` is 1 whenever `pull_low_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Main power below threshold (synchronous) |
| osc_run_i | input | 1 | Oscillator running |
| pin_i | input | 1 | Sensed level of the reset line (asynchronous) |
| pull_low_o | output | 1 | Enable for the open-drain pull-down of the line |
| busy_o | output | 1 | A power-fail or button sequence is in progress |

## Verification
A button falling edge and a power-fail assertion can both be present in the same cycle. The bench provokes this by raising `pwr_fail_i` in exactly the cycle in which the synchronised falling edge first becomes visible to the controller. The outcome is judged by the length of the single low run that follows: it must equal the power-fail hold plus the recovery interval, with no debounce or reset pulse afterwards. A second case raises power-fail one cycle into debounce. There, the run must be one debounce cycle longer, and releasing the button later must start nothing.

// File: rtl/pbrst_pkg.sv
package pbrst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PFAIL = 3'd1,
    ST_RECOV = 3'd2,
    ST_DEBNC = 3'd3,
    ST_WREL  = 3'd4,
    ST_PULSE = 3'd5
  } pbrst_state_e;

  function automatic bit drives_low(pbrst_state_e s);
    return (s == ST_PFAIL) || (s == ST_RECOV) || (s == ST_DEBNC) || (s == ST_PULSE);
  endfunction
endpackage

// File: rtl/pbrst_sync.sv
module pbrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_fall
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = pin_async;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], pin_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign pin_lvl  = sh_q[STAGES-1];
  assign pin_fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/pbrst_timer.sv
module pbrst_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pbrst_fsm.sv
module pbrst_fsm
  import pbrst_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DB_LOAD  = 1,
  parameter int unsigned RST_LOAD = 1,
  parameter int unsigned REC_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             osc_run,
  input  logic             pin_lvl,
  input  logic             pin_fall,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output pbrst_state_e     state
);
  localparam logic [CNT_W-1:0] DB_V  = CNT_W'(DB_LOAD);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_LOAD);
  localparam logic [CNT_W-1:0] REC_V = CNT_W'(REC_LOAD);

  pbrst_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (pwr_fail) begin
      st_d = ST_PFAIL;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pin_fall) begin
          st_d = ST_DEBNC; tmr_load = 1'b1; tmr_val = DB_V;
        end
        ST_PFAIL: if (osc_run) begin
          st_d = ST_RECOV; tmr_load = 1'b1; tmr_val = REC_V;
        end else begin
          st_d = ST_IDLE;
        end
        ST_RECOV: if (tmr_done) st_d = ST_IDLE;
        ST_DEBNC: if (tmr_done) st_d = ST_WREL;
        ST_WREL:  if (pin_lvl) begin
          st_d = ST_PULSE; tmr_load = 1'b1; tmr_val = RST_V;
        end
        ST_PULSE: if (tmr_done) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pbrst_ctl.sv
module pbrst_ctl
  import pbrst_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 8000000,
  parameter int unsigned RESET_TICKS    = 8000000,
  parameter int unsigned RECOVER_TICKS  = 8000000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic osc_run_i,
  input  logic pin_i,
  output logic pull_low_o,
  output logic busy_o
);
  localparam int unsigned MAX_T1 = (DEBOUNCE_TICKS > RESET_TICKS) ? DEBOUNCE_TICKS : RESET_TICKS;
  localparam int unsigned MAX_T  = (MAX_T1 > RECOVER_TICKS) ? MAX_T1 : RECOVER_TICKS;
  localparam int unsigned CNT_W  = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  logic             pin_lvl, pin_fall, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  pbrst_state_e     state;

  pbrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_i),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall)
  );

  pbrst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(tmr_val), .done(tmr_done)
  );

  pbrst_fsm #(
    .CNT_W(CNT_W), .DB_LOAD(DEBOUNCE_TICKS - 1),
    .RST_LOAD(RESET_TICKS - 1), .REC_LOAD(RECOVER_TICKS - 1)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail_i), .osc_run(osc_run_i),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state)
  );

  assign pull_low_o = drives_low(state);
  assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/pbrst_ctl_chk.sv
module pbrst_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail_i,
  input logic osc_run_i,
  input logic pull_low_o,
  input logic busy_o
);
  a_r6_pf_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> pull_low_o);

  a_r7_recover_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_fail_i) && osc_run_i) |=> pull_low_o);

  a_r8_no_osc_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_fail_i) && !osc_run_i) |=> !pull_low_o);

  a_r10_busy_covers_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> busy_o);
endmodule

bind pbrst_ctl pbrst_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i), .osc_run_i(osc_run_i),
  .pull_low_o(pull_low_o), .busy_o(busy_o)
);

// File: tb/pbrst_ctl_bench.sv
module pbrst_ctl_bench;
  localparam int DB  = 6;
  localparam int RST = 9;
  localparam int REC = 7;
  localparam int P   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic osc_run = 1'b1;
  logic btn = 1'b0;
  logic pin, pull_low, busy;
  int   checks = 0;
  int   errors = 0;
  int   exp_q[$];
  int   run_len = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  assign pin = !(btn || pull_low);

  pbrst_ctl #(
    .DEBOUNCE_TICKS(DB), .RESET_TICKS(RST), .RECOVER_TICKS(REC)
  ) u_pbrst_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .osc_run_i(osc_run),
    .pin_i(pin), .pull_low_o(pull_low), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_run(input int len);
    exp_q.push_back(len);
  endtask

  // monitor: measures each low-drive run and pops the expected length
  always @(negedge clk) begin
    if (rst_n) begin
      if (pull_low) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected run", run_len, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(run_len == e, "R2/R4/R7/R9 run length", run_len, e);
        end
        run_len = 0;
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    negs(3);
    rst_n = 1'b1;
    negs(1);
    check(pull_low == 1'b0, "R1 pull_low", int'(pull_low), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);

    // R2 R3 R4: held press, released later
    expect_run(DB); expect_run(RST);
    btn = 1'b1;
    negs(2);
    check(pull_low == 1'b0, "R2 latency early", int'(pull_low), 0);
    negs(1);
    check(pull_low == 1'b1, "R2 drive at third edge", int'(pull_low), 1);
    negs(DB + 3);
    check(pull_low == 1'b0, "R3 released while held", int'(pull_low), 0);
    check(busy == 1'b1, "R3 busy while waiting", int'(busy), 1);
    btn = 1'b0;
    negs(RST + 12);
    check(busy == 1'b0, "R4 idle after pulse", int'(busy), 0);

    // R5: short press released during debounce
    expect_run(DB); expect_run(RST);
    btn = 1'b1; negs(4); btn = 1'b0;
    negs(DB + RST + 30);
    check(exp_q.size() == 0, "R5 exactly two runs", exp_q.size(), 0);
    check(busy == 1'b0, "R5 idle", int'(busy), 0);

    // R6 R7 R10: power fail with oscillator running
    expect_run(P + REC);
    pwr_fail = 1'b1; negs(1);
    check(pull_low == 1'b1, "R6 drive on fail", int'(pull_low), 1);
    check(busy == 1'b1, "R10 busy with drive", int'(busy), 1);
    negs(P - 1); pwr_fail = 1'b0;
    negs(REC + 5);
    check(pull_low == 1'b0, "R7 released after recovery", int'(pull_low), 0);

    // R8: oscillator stopped
    expect_run(P);
    osc_run = 1'b0; pwr_fail = 1'b1; negs(P); pwr_fail = 1'b0;
    negs(1);
    check(pull_low == 1'b0, "R8 immediate release", int'(pull_low), 0);
    osc_run = 1'b1;
    negs(5);

    // R9: power fail aborts debounce
    expect_run(1 + P + REC);
    btn = 1'b1; negs(3);
    check(pull_low == 1'b1, "R9 debounce started", int'(pull_low), 1);
    pwr_fail = 1'b1; negs(P); pwr_fail = 1'b0;
    negs(REC + 10); btn = 1'b0; negs(20);
    check(exp_q.size() == 0 && !busy, "R9 abort no pulse", exp_q.size(), 0);

    // R9: press and release during power fail
    expect_run(P + REC);
    pwr_fail = 1'b1; negs(3); btn = 1'b1; negs(3); btn = 1'b0;
    negs(P - 6); pwr_fail = 1'b0;
    negs(REC + 20);
    check(exp_q.size() == 0 && !busy, "R9 press ignored in fail", exp_q.size(), 0);

    // R9: falling edge and power fail in the same cycle
    expect_run(P + REC);
    btn = 1'b1; negs(2);
    check(pull_low == 1'b0, "R9 coincident pre", int'(pull_low), 0);
    pwr_fail = 1'b1; negs(P); pwr_fail = 1'b0;
    negs(REC + 10); btn = 1'b0; negs(20);
    check(exp_q.size() == 0 && !busy, "R9 coincident priority", exp_q.size(), 0);
    check(run_len == 0, "R5 no open run", run_len, 0);

    finish_up();
  end
endmodule